// File: doc/BRIEF.md
# Eight-Bit CPU Bus Cycle Sequencer

This block sits between the core of an 8-bit processor and its external bus. The address is 16 bits wide. The core asks for one transfer at a time by giving a cycle kind, an address and write data. The sequencer then steps through the clock periods of that transfer (T-states). Some strobe edges are launched on the rising clock edge and others on the falling edge. When the transfer ends, the sequencer returns a one-clock done strobe together with any data it read.

Five transfer kinds are supported:
- opcode fetch;
- memory read;
- memory write;
- I/O read;
- I/O write.

Every opcode fetch ends with a refresh slot for dynamic memory. During that slot a 7-bit refresh count is placed on the low address lines and the refresh strobe is asserted. The count then advances.

Memory-not-ready (`wait_n`) stretches a transfer one clock at a time. An external bus master can take over the buses at any cycle boundary. While it holds them, every driven line is released and an acknowledge output is pulled low.

All strobes are active low. Output enables are provided separately, so tristate pads can be placed at chip level. A cycle always starts and ends at one idle clock. The first cycle after reset is a fetch, and the sequencer starts it by itself.

Top module: `cpu_bus_seq`

## Requirements
- R1: While `rst_n` is low, the following hold:
  - `addr_oe`, `dbus_oe` and `ctl_oe` are 0;
  - `mreq_n`, `iorq_n`, `rd_n`, `wr_n`, `m1_n` and `rfsh_n` are 1;
  - `busack_n` is 1.
- R2: On the first rising edge after reset is released, the sequencer starts an opcode fetch from address 0x0000. No request is needed. It ends with `done` and the fetched byte, like any other fetch.
- R3: In an opcode fetch, the signals behave as follows:
  - `m1_n` is low from the rising edge that starts T1 until the rising edge that starts T3.
  - `mreq_n` and `rd_n` fall on the falling edge inside T1 and rise on the rising edge that starts T3.
  - The byte on `dbus_i` at that rising edge is the fetched data.
- R4: A fetch continues with T3 and T4, which form the refresh slot:
  - `rfsh_n` is low for the whole slot;
  - `rd_n` and `m1_n` are high for the whole slot;
  - `addr_o` equals 0x00 in the high byte and the refresh register in the low byte;
  - `mreq_n` is low from the falling edge in T3 to the falling edge in T4.
- R5: The refresh register resets to 0. Its low 7 bits increment by one at the end of every fetch and wrap from 127 to 0. Bit 7 never changes, so A7 stays 0 in every refresh slot.
- R6: In a memory read (kind 1), the signals behave as follows:
  - `mreq_n` and `rd_n` fall on the falling edge in T1 and rise on the falling edge in T3;
  - `rdata` takes the byte on `dbus_i` at that falling edge;
  - `m1_n` and `rfsh_n` stay high.
- R7: In a memory write (kind 2), the signals behave as follows:
  - `dbus_o` carries the write data with `dbus_oe` high from the start of T1 to the end of T3;
  - `mreq_n` falls on the falling edge in T1;
  - `wr_n` falls on the falling edge in T2;
  - both rise on the falling edge in T3;
  - `rd_n` stays high.
- R8: I/O read (kind 3) and I/O write (kind 4) use exactly the timing of kinds 1 and 2, with `iorq_n` in place of `mreq_n`. During these cycles `mreq_n` stays high, and the low byte of `addr_o` is the port number from `req_addr[7:0]`.
- R9: Each rising edge that ends T2 or a wait state with `wait_n` low adds one more wait state. During a wait state all strobes keep their levels. The read data is taken only after `wait_n` is seen high.
- R10: Bus requests are handled as follows:
  - When `busreq_n` is low at a rising edge in an idle clock, the next state is hold. This takes priority over a pending request.
  - In hold, `busack_n` is low; `addr_oe`, `dbus_oe` and `ctl_oe` are 0; all strobes are high; no cycle starts.
  - `busack_n` returns high on the first rising edge that sees `busreq_n` high.
- R11: Requests and completion work as follows:
  - A request is taken at a rising edge in an idle clock when `req` is high.
  - `req_type` is encoded as 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write.
  - After the last T-state the sequencer spends one idle clock with `done` high. `done` is low in every other clock.
  - `rdata` holds the last byte read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; T-states begin on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request a transfer (taken in an idle clock) |
| req_type | input | 3 | Transfer kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| req_addr | input | 16 | Transfer address (I/O port in the low byte) |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-clock completion strobe |
| addr_o | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| dbus_i | input | 8 | Data bus input |
| dbus_o | output | 8 | Data bus value when writing |
| dbus_oe | output | 1 | Data bus drive enable |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Opcode fetch marker |
| rfsh_n | output | 1 | Refresh strobe |
| ctl_oe | output | 1 | Drive enable for mreq_n, iorq_n, rd_n, wr_n |
| wait_n | input | 1 | Memory not ready when low |
| busreq_n | input | 1 | External bus request |
| busack_n | output | 1 | Bus granted |

## Verification
The assertions make four assumptions about the inputs:
- `wait_n`, `busreq_n`, `req` and `dbus_i` are steady around the clock edges that sample them;
- `req_type` uses a legal kind;
- `rst_n` is held low for at least three clocks;
- `req` is dropped once a transfer has been taken.

The stimulus honours all four. It changes every input 1 ns after an edge, and it drops `req` in the first half of T1. It holds reset for four clocks. It puts the correct read byte on `dbus_i` only in the half clock that precedes the expected sampling edge, and drives its complement elsewhere, so a wrong sampling edge shows up as wrong data.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_TW   = 3'd3,
      PH_T3   = 3'd4,
      PH_T4   = 3'd5,
      PH_HOLD = 3'd6
   } phase_e;

   typedef enum logic [2:0] {
      CYC_FETCH = 3'd0,
      CYC_MRD   = 3'd1,
      CYC_MWR   = 3'd2,
      CYC_IORD  = 3'd3,
      CYC_IOWR  = 3'd4
   } cyc_e;

   function automatic logic cyc_is_write(cyc_e c);
      return (c == CYC_MWR) || (c == CYC_IOWR);
   endfunction

   function automatic logic cyc_is_io(cyc_e c);
      return (c == CYC_IORD) || (c == CYC_IOWR);
   endfunction

   function automatic logic ph_is_access(phase_e p);
      return (p == PH_T1) || (p == PH_T2) || (p == PH_TW);
   endfunction

   function automatic cyc_e cyc_from_code(logic [2:0] code);
      cyc_e c;
      case (code)
         3'd0:    c = CYC_FETCH;
         3'd1:    c = CYC_MRD;
         3'd2:    c = CYC_MWR;
         3'd3:    c = CYC_IORD;
         3'd4:    c = CYC_IOWR;
         default: c = CYC_MRD;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bseq_fsm.sv
`timescale 1ns/1ps
module bseq_fsm
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BOOT_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [2:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              wait_n,
   input  logic              busreq_n,
   input  logic [DATA_W-1:0] dbus_i,
   input  logic [DATA_W-1:0] late_data,
   output phase_e            ph,
   output cyc_e              cyc,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              run,
   output logic              rfsh_adv
);

   localparam logic [ADDR_W-1:0] BOOT_VEC = ADDR_W'(BOOT_ADDR);

   phase_e ph_q;
   cyc_e   cyc_q;
   logic   boot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cyc_q   <= CYC_FETCH;
         addr_q  <= BOOT_VEC;
         wdata_q <= '0;
         rdata   <= '0;
         done    <= 1'b0;
         boot_q  <= 1'b1;
         run     <= 1'b0;
      end else begin
         run  <= 1'b1;
         done <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (!busreq_n) begin
                  ph_q <= PH_HOLD;
               end else if (boot_q || req) begin
                  ph_q    <= PH_T1;
                  boot_q  <= 1'b0;
                  cyc_q   <= boot_q ? CYC_FETCH : cyc_from_code(req_type);
                  addr_q  <= boot_q ? BOOT_VEC : req_addr;
                  wdata_q <= req_wdata;
               end
            end
            PH_T1: ph_q <= PH_T2;
            PH_T2, PH_TW: begin
               if (wait_n) begin
                  ph_q <= PH_T3;
                  if (cyc_q == CYC_FETCH) rdata <= dbus_i;
               end else begin
                  ph_q <= PH_TW;
               end
            end
            PH_T3: begin
               if (cyc_q == CYC_FETCH) begin
                  ph_q <= PH_T4;
               end else begin
                  ph_q <= PH_IDLE;
                  done <= 1'b1;
                  if (!cyc_is_write(cyc_q)) rdata <= late_data;
               end
            end
            PH_T4: begin
               ph_q <= PH_IDLE;
               done <= 1'b1;
            end
            PH_HOLD: begin
               if (busreq_n) ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ph       = ph_q;
   assign cyc      = cyc_q;
   assign rfsh_adv = (ph_q == PH_T4);

   // R9
   wait_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((ph_q == PH_T2) || (ph_q == PH_TW)) && !wait_n) |=> (ph_q == PH_TW));

   // R10
   grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q == PH_IDLE) && !busreq_n) |=> (ph_q == PH_HOLD));

   // R10
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q == PH_HOLD) && busreq_n) |=> (ph_q == PH_IDLE));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ph_q == PH_IDLE || ph_q == PH_HOLD || ph_q == PH_T1));

endmodule

// File: rtl/bseq_half.sv
`timescale 1ns/1ps
module bseq_half
   import bseq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            ph,
   input  logic [DATA_W-1:0] dbus_i,
   output phase_e            ph_n,
   output logic [DATA_W-1:0] late_data
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_n      <= PH_IDLE;
         late_data <= '0;
      end else begin
         ph_n <= ph;
         if (ph == PH_T3) late_data <= dbus_i;
      end
   end

endmodule

// File: rtl/bseq_refresh.sv
`timescale 1ns/1ps
module bseq_refresh #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned RFSH_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [DATA_W-1:0] raddr
);

   generate
      if (RFSH_W == DATA_W) begin : g_full
         logic [DATA_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (adv) cnt_q <= cnt_q + DATA_W'(1);
         end
         assign raddr = cnt_q;

         // R5
         rfsh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            adv |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));
      end else begin : g_split
         logic [RFSH_W-1:0]        lo_q;
         logic [DATA_W-RFSH_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= '0;
               hi_q <= '0;
            end else if (adv) begin
               lo_q <= lo_q + RFSH_W'(1);
               hi_q <= hi_q;
            end
         end
         assign raddr = {hi_q, lo_q};

         // R5
         rfsh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            adv |=> ((lo_q == $past(lo_q) + RFSH_W'(1)) && (hi_q == $past(hi_q))));
      end
   endgenerate

endmodule

// File: rtl/bseq_strobe.sv
`timescale 1ns/1ps
module bseq_strobe
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            ph,
   input  phase_e            ph_n,
   input  cyc_e              cyc,
   input  logic              run,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [DATA_W-1:0] raddr,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   output logic [DATA_W-1:0] dbus_o,
   output logic              dbus_oe,
   output logic              mreq_n,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              m1_n,
   output logic              rfsh_n,
   output logic              ctl_oe,
   output logic              busack_n
);

   localparam int unsigned PAD_W = ADDR_W - DATA_W;

   logic early_act, late_act, late_wr, fetch, wrt, io, slot, slot_mreq, hold;

   always_comb begin
      early_act = ph_is_access(ph);
      late_act  = ph_is_access(ph_n);
      late_wr   = (ph_n == PH_T2) || (ph_n == PH_TW);
      fetch     = (cyc == CYC_FETCH);
      wrt       = cyc_is_write(cyc);
      io        = cyc_is_io(cyc);
      slot      = fetch && ((ph == PH_T3) || (ph == PH_T4));
      slot_mreq = slot && (ph_n == PH_T3);
      hold      = (ph == PH_HOLD);

      m1_n   = !(fetch && early_act);
      rfsh_n = !slot;
      mreq_n = !((fetch && ((early_act && late_act) || slot_mreq)) ||
                 (!fetch && !io && late_act));
      iorq_n = !(io && late_act);
      rd_n   = !((fetch && early_act && late_act) || (!fetch && !wrt && late_act));
      wr_n   = !(wrt && late_wr);

      addr_o  = slot ? {{PAD_W{1'b0}}, raddr} : addr_q;
      addr_oe = run && !hold;
      ctl_oe  = run && !hold;
      dbus_o  = wdata_q;
      dbus_oe = run && !hold && wrt && (early_act || (ph == PH_T3));

      busack_n = !hold;
   end

   // R8
   iorq_mreq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mreq_n && !iorq_n));

   // R7
   wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (!mreq_n || !iorq_n));

   // R4
   rfsh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> (rd_n && m1_n && wr_n));

   // R3
   fetch_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !m1_n) |-> !mreq_n);

   // R10
   hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busack_n |-> (!addr_oe && !dbus_oe && !ctl_oe && mreq_n && iorq_n));

endmodule

// File: rtl/cpu_bus_seq.sv
`timescale 1ns/1ps
module cpu_bus_seq
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RFSH_W    = 7,
   parameter int unsigned BOOT_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [2:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe,
   input  logic [DATA_W-1:0] dbus_i,
   output logic [DATA_W-1:0] dbus_o,
   output logic              dbus_oe,
   output logic              mreq_n,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              m1_n,
   output logic              rfsh_n,
   output logic              ctl_oe,
   input  logic              wait_n,
   input  logic              busreq_n,
   output logic              busack_n
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_addr
         $error("cpu_bus_seq: ADDR_W must exceed DATA_W");
      end
      if (RFSH_W < 1 || RFSH_W > DATA_W) begin : g_bad_rfsh
         $error("cpu_bus_seq: RFSH_W must lie in 1..DATA_W");
      end
      if ((BOOT_ADDR >> ADDR_W) != 0) begin : g_bad_boot
         $error("cpu_bus_seq: BOOT_ADDR does not fit ADDR_W");
      end
   endgenerate

   phase_e            ph, ph_n;
   cyc_e              cyc;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, late_data, raddr;
   logic              run, rfsh_adv;

   bseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_ADDR(BOOT_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .req_type(req_type),
      .req_addr(req_addr), .req_wdata(req_wdata), .wait_n(wait_n),
      .busreq_n(busreq_n), .dbus_i(dbus_i), .late_data(late_data),
      .ph(ph), .cyc(cyc), .addr_q(addr_q), .wdata_q(wdata_q),
      .rdata(rdata), .done(done), .run(run), .rfsh_adv(rfsh_adv)
   );

   bseq_half #(.DATA_W(DATA_W)) u_half (
      .clk(clk), .rst_n(rst_n), .ph(ph), .dbus_i(dbus_i),
      .ph_n(ph_n), .late_data(late_data)
   );

   bseq_refresh #(.DATA_W(DATA_W), .RFSH_W(RFSH_W)) u_rfsh (
      .clk(clk), .rst_n(rst_n), .adv(rfsh_adv), .raddr(raddr)
   );

   bseq_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strb (
      .clk(clk), .rst_n(rst_n), .ph(ph), .ph_n(ph_n), .cyc(cyc), .run(run),
      .addr_q(addr_q), .wdata_q(wdata_q), .raddr(raddr),
      .addr_o(addr_o), .addr_oe(addr_oe), .dbus_o(dbus_o), .dbus_oe(dbus_oe),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
      .m1_n(m1_n), .rfsh_n(rfsh_n), .ctl_oe(ctl_oe), .busack_n(busack_n)
   );

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!addr_oe && !dbus_oe && !ctl_oe && mreq_n && iorq_n &&
                                  rd_n && wr_n && m1_n && rfsh_n && busack_n);
      end
   end

endmodule

// File: tb/sim_cpu_bus_seq.sv
`timescale 1ns/1ps
module sim_cpu_bus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  req_type = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic [7:0]  rdata;
   logic        done;
   logic [15:0] addr_o;
   logic        addr_oe;
   logic [7:0]  dbus_i = 8'h00;
   logic [7:0]  dbus_o;
   logic        dbus_oe;
   logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, ctl_oe;
   logic        wait_n = 1'b1;
   logic        busreq_n = 1'b1;
   logic        busack_n;

   int tests = 0;
   int fails = 0;
   bit finished = 0;
   logic [6:0] rexp = 7'd0;

   always #2.5 clk = ~clk;

   cpu_bus_seq u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_type(req_type),
      .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .done(done),
      .addr_o(addr_o), .addr_oe(addr_oe), .dbus_i(dbus_i), .dbus_o(dbus_o),
      .dbus_oe(dbus_oe), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
      .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .ctl_oe(ctl_oe),
      .wait_n(wait_n), .busreq_n(busreq_n), .busack_n(busack_n)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_quiet(input string tag);
      logic [9:0] v;
      v = {addr_oe, dbus_oe, ctl_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, done};
      chk(v == 10'b0001111110, tag, {22'd0, v}, 32'h07E);
   endtask

   // One bus cycle with nw wait states; expected levels derived per half clock
   task automatic do_cycle(input logic [2:0] ty, input logic [15:0] ad,
                           input logic [7:0] wd, input int nw, input logic [7:0] rb,
                           input bit drive_req, input string tag0);
      int  L;
      int  nh;
      bit  fetch, wrt, io;
      string tag;
      L     = 2 + nw;
      fetch = (ty == 3'd0);
      wrt   = (ty == 3'd2) || (ty == 3'd4);
      io    = (ty == 3'd3) || (ty == 3'd4);
      nh    = fetch ? 2 * (L + 2) : 2 * (L + 1);
      tag   = (nw > 0) ? {tag0, " R9"} : tag0;
      if (drive_req) begin
         req = 1'b1; req_type = ty; req_addr = ad; req_wdata = wd;
      end
      for (int h = 0; h < nh; h++) begin
         int k;
         int hf;
         bit acc, f_mreq, f_rd, w_wr;
         logic [9:0] ev, av;
         logic [15:0] ea;
         k  = h / 2;
         hf = h % 2;
         if (hf == 0) begin @(posedge clk); #1; end
         else         begin @(negedge clk); #1; end
         if (h == 0) req = 1'b0;
         acc    = (k == 0 && hf == 1) || (k >= 1 && k < L) || (k == L && hf == 0);
         f_rd   = (k == 0 && hf == 1) || (k >= 1 && k < L);
         f_mreq = f_rd || (k == L && hf == 1) || (k == L + 1 && hf == 0);
         w_wr   = (k == 1 && hf == 1) || (k >= 2 && k < L) || (k == L && hf == 0);
         ev[9] = !(fetch && k < L);                               // m1_n
         ev[8] = !(fetch ? f_mreq : (!io && acc));                // mreq_n
         ev[7] = !(io && acc);                                    // iorq_n
         ev[6] = !(fetch ? f_rd : (!wrt && acc));                 // rd_n
         ev[5] = !(wrt && w_wr);                                  // wr_n
         ev[4] = !(fetch && k >= L);                              // rfsh_n
         ev[3] = 1'b0;                                            // done
         ev[2] = 1'b1;                                            // addr_oe
         ev[1] = 1'b1;                                            // ctl_oe
         ev[0] = wrt && (k <= L);                                 // dbus_oe
         av = {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, done, addr_oe, ctl_oe, dbus_oe};
         chk(av == ev, tag, {22'd0, av}, {22'd0, ev});
         ea = (fetch && k >= L) ? {8'h00, 1'b0, rexp} : ad;
         chk(addr_o == ea, (fetch && k >= L) ? "R4 R5" : tag, {16'd0, addr_o}, {16'd0, ea});
         if (wrt && k <= L) chk(dbus_o == wd, "R7", {24'd0, dbus_o}, {24'd0, wd});
         wait_n = (k >= 1 + nw);
         if (fetch) dbus_i = (k == L - 1 && hf == 1) ? rb : ~rb;
         else       dbus_i = (k == L && hf == 0) ? rb : ~rb;
      end
      @(posedge clk); #1;
      wait_n = 1'b1;
      chk(done == 1'b1, "R11", {31'd0, done}, 32'd1);
      if (!wrt) chk(rdata == rb, fetch ? tag0 : "R6 R11", {24'd0, rdata}, {24'd0, rb});
      if (fetch) rexp = rexp + 7'd1;
   endtask

   initial begin
      logic [15:0] ad;
      logic [7:0]  wd, rb, keep;
      // R1: reset held for four clocks, both halves checked
      repeat (4) begin
         @(posedge clk); #1; chk_quiet("R1");
         chk(busack_n == 1'b1, "R1", {31'd0, busack_n}, 32'd1);
         @(negedge clk); #1; chk_quiet("R1");
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      // R2: automatic fetch from 0x0000
      do_cycle(3'd0, 16'h0000, 8'h00, 0, 8'h3C, 0, "R2 R3");
      // R11: done lasts one clock
      @(posedge clk); #1;
      chk(done == 1'b0, "R11", {31'd0, done}, 32'd0);
      // sweep over every kind and 0..3 wait states
      for (int ty = 0; ty < 5; ty++) begin
         for (int nw = 0; nw < 4; nw++) begin
            ad = 16'h1234 ^ 16'(ty << 12) ^ 16'(nw * 16'h0101);
            wd = 8'hA5 + 8'(ty * 7 + nw);
            rb = 8'h5A ^ 8'(ty * 16 + nw);
            case (ty)
               0: do_cycle(3'(ty), ad, wd, nw, rb, 1, "R3 R4");
               1: do_cycle(3'(ty), ad, wd, nw, rb, 1, "R6");
               2: do_cycle(3'(ty), ad, wd, nw, rb, 1, "R7");
               default: do_cycle(3'(ty), ad, wd, nw, rb, 1, "R8");
            endcase
         end
      end
      // R11: a write leaves rdata unchanged
      keep = rdata;
      do_cycle(3'd2, 16'h4321, 8'h99, 0, 8'h00, 1, "R7");
      chk(rdata == keep, "R11", {24'd0, rdata}, {24'd0, keep});
      // R5: run the refresh count through its wrap
      for (int n = 0; n < 130; n++) begin
         do_cycle(3'd0, 16'(n * 16'h0203), 8'h00, 0, 8'(n), 1, "R5");
      end
      // R10: bus request in an idle clock, with a read pending
      busreq_n = 1'b0;
      req = 1'b1; req_type = 3'd1; req_addr = 16'hBEEF;
      @(posedge clk); #1;
      chk(busack_n == 1'b0, "R10", {31'd0, busack_n}, 32'd0);
      chk_quiet("R10");
      repeat (3) begin
         @(negedge clk); #1; chk_quiet("R10");
         @(posedge clk); #1; chk_quiet("R10");
         chk(busack_n == 1'b0, "R10", {31'd0, busack_n}, 32'd0);
      end
      busreq_n = 1'b1;
      @(negedge clk); #1;
      chk(busack_n == 1'b0, "R10", {31'd0, busack_n}, 32'd0);
      @(posedge clk); #1;
      chk(busack_n == 1'b1, "R10", {31'd0, busack_n}, 32'd1);
      chk({ctl_oe, addr_oe, mreq_n} == 3'b111, "R10", {29'd0, ctl_oe, addr_oe, mreq_n}, 32'd7);
      do_cycle(3'd1, 16'hBEEF, 8'h00, 0, 8'h77, 1, "R10 R6");
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule